// File: doc/BRIEF.md
# Orientation-Aware Lane Swap Crossbar

This block sits between a four-lane display link encoder/decoder and four serial transceiver channels. It reroutes each parallel data word, with its control sideband and valid flag, so that the protocol side always sees its own lane numbering. The connector orientation and the number of active lanes set the routing. A flipped reversible connector mirrors the channel order. A reduced-width link that is flipped moves onto the upper channels.

The transmit path takes lane-indexed words and drives channel-indexed words. The receive path does the reverse and applies the same mapping. The orientation bit comes from an external detector. It and the lane-count code are loaded into a configuration register only by a load strobe given while the link is held in reset. Traffic therefore never sees a mapping change inside a word. Each path has exactly one register stage.

Top module: `lane_swap_xbar`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the configuration is normal orientation with four lanes. Every channel and lane output has valid and sideband at 0. Transmit channels carry `IDLE_WORD` and receive lanes carry zero data.
- R2: In normal orientation, lane i is routed to and from channel i, for every active lane i.
- R3: In flipped orientation with four lanes (code 2), lane i is routed to and from channel 3-i.
- R4: In flipped orientation with two lanes (code 1), lane 0 uses channel 3 and lane 1 uses channel 2. Channels 0 and 1 are unused.
- R5: With one lane (code 0), lane 0 uses channel 0 in normal orientation and channel 3 when flipped.
- R6: An unused transmit channel outputs `IDLE_WORD` with sideband 0 and valid 0. An unused receive lane outputs all zeros with valid 0, whatever the unused inputs carry.
- R7: The sideband bits and the valid flag of each word follow the same permutation as its data. An inactive-valid word on an active lane is passed through unchanged.
- R8: A word sampled at a clock edge appears on the mapped output one cycle later, whatever the mapping.
- R9: `flip_in` and `width_in` are loaded at a clock edge only when `cfg_load` and `link_hold` are both high. Otherwise the mapping stays unchanged.
- R10: A load with the reserved lane-count code 3 is ignored and leaves the whole configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_hold | input | 1 | High while the link is held in reset; enables loading |
| cfg_load | input | 1 | Configuration load strobe |
| flip_in | input | 1 | Connector flipped (1) or normal (0) |
| width_in | input | 2 | Lane count code: 0 = one, 1 = two, 2 = four, 3 reserved |
| tx_lane_data | input | 4x DATA_W | Transmit words per protocol lane |
| tx_lane_side | input | 4x SIDE_W | Transmit control sideband per lane |
| tx_lane_vld | input | 4 | Transmit valid per lane |
| tx_ch_data | output | 4x DATA_W | Transmit words per transceiver channel |
| tx_ch_side | output | 4x SIDE_W | Transmit sideband per channel |
| tx_ch_vld | output | 4 | Transmit valid per channel |
| rx_ch_data | input | 4x DATA_W | Receive words per transceiver channel |
| rx_ch_side | input | 4x SIDE_W | Receive sideband per channel |
| rx_ch_vld | input | 4 | Receive valid per channel |
| rx_lane_data | output | 4x DATA_W | Receive words per protocol lane |
| rx_lane_side | output | 4x SIDE_W | Receive sideband per lane |
| rx_lane_vld | output | 4 | Receive valid per lane |

## Verification
The assertions assume `rst` is high at the first clock edge. They do not assume that the strobe is only given with `link_hold` or with a legal code. Instead they check that such loads are absorbed. The valid-count checks rely on the mapping being a permutation of the active positions. The bench drives random words, sidebands and valid flags on all eight input groups, including lanes that are unused. It gives loads both with and without `link_hold` and once with code 3. The random ending phase also toggles the strobe freely, so the absorbed cases come up often.

// File: rtl/laneswap_pkg.sv
package laneswap_pkg;

    // The permutation is defined for a four-channel connector.
    localparam int unsigned NCH = 4;

    typedef enum logic [1:0] {
        WIDTH_X1   = 2'd0,
        WIDTH_X2   = 2'd1,
        WIDTH_X4   = 2'd2,
        WIDTH_RSVD = 2'd3
    } width_e;

    typedef struct packed {
        logic   flip;
        width_e width;
    } map_cfg_t;

    localparam map_cfg_t CFG_RESET = '{flip: 1'b0, width: WIDTH_X4};

    function automatic logic [2:0] active_count(width_e w);
        case (w)
            WIDTH_X1: return 3'd1;
            WIDTH_X2: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    // Mirror a position index when the connector is flipped.
    function automatic logic [1:0] mirror(logic flip, logic [1:0] idx);
        return flip ? (2'd3 - idx) : idx;
    endfunction

endpackage

// File: rtl/laneswap_cfg.sv
module laneswap_cfg
    import laneswap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       link_hold,
    input  logic       cfg_load,
    input  logic       flip_in,
    input  logic [1:0] width_in,
    output map_cfg_t   cfg
);

    logic accept;
    assign accept = cfg_load && link_hold && (width_e'(width_in) != WIDTH_RSVD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (accept) begin
            cfg.flip  <= flip_in;
            cfg.width <= width_e'(width_in);
        end
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_load && link_hold) |=> $stable(cfg));

    // R10
    cfg_code_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.width != WIDTH_RSVD);

endmodule

// File: rtl/laneswap_path.sv
module laneswap_path
    import laneswap_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SIDE_W    = 2,
    parameter bit          IS_TX     = 1'b1,
    parameter logic [DATA_W-1:0] IDLE_WORD = '0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  map_cfg_t                    cfg,
    input  logic [NCH-1:0][DATA_W-1:0]  in_data,
    input  logic [NCH-1:0][SIDE_W-1:0]  in_side,
    input  logic [NCH-1:0]              in_vld,
    output logic [NCH-1:0][DATA_W-1:0]  out_data,
    output logic [NCH-1:0][SIDE_W-1:0]  out_side,
    output logic [NCH-1:0]              out_vld
);

    // Filler for positions outside the active link width.
    localparam logic [DATA_W-1:0] FILL = IS_TX ? IDLE_WORD : '0;

    logic [2:0] n_act;
    assign n_act = active_count(cfg.width);

    for (genvar p = 0; p < NCH; p++) begin : g_pos
        logic [1:0] src;
        logic [1:0] lane_of_pos;
        logic       act;

        always_comb begin
            src = mirror(cfg.flip, 2'(p));
            // Transmit outputs are channels; receive outputs are lanes.
            lane_of_pos = IS_TX ? src : 2'(p);
            act = ({1'b0, lane_of_pos} < n_act);
        end

        always_ff @(posedge clk) begin
            if (rst || !act) begin
                out_data[p] <= FILL;
                out_side[p] <= '0;
                out_vld[p]  <= 1'b0;
            end else begin
                out_data[p] <= in_data[src];
                out_side[p] <= in_side[src];
                out_vld[p]  <= in_vld[src];
            end
        end
    end

    // Inputs that feed an active output (used only by the checks below).
    logic [NCH-1:0] in_used;
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            in_used[i] = ({1'b0, (IS_TX ? 2'(i) : mirror(cfg.flip, 2'(i)))} < n_act);
        end
    end

    // R6
    vld_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(out_vld) <= int'($past(n_act)));

    // R7
    vld_carry_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $countones(out_vld) == $countones($past(in_vld & in_used)));

endmodule

// File: rtl/lane_swap_xbar.sv
module lane_swap_xbar
    import laneswap_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SIDE_W    = 2,
    parameter logic [DATA_W-1:0] IDLE_WORD = 16'hBC1C
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        link_hold,
    input  logic                        cfg_load,
    input  logic                        flip_in,
    input  logic [1:0]                  width_in,
    input  logic [NCH-1:0][DATA_W-1:0]  tx_lane_data,
    input  logic [NCH-1:0][SIDE_W-1:0]  tx_lane_side,
    input  logic [NCH-1:0]              tx_lane_vld,
    output logic [NCH-1:0][DATA_W-1:0]  tx_ch_data,
    output logic [NCH-1:0][SIDE_W-1:0]  tx_ch_side,
    output logic [NCH-1:0]              tx_ch_vld,
    input  logic [NCH-1:0][DATA_W-1:0]  rx_ch_data,
    input  logic [NCH-1:0][SIDE_W-1:0]  rx_ch_side,
    input  logic [NCH-1:0]              rx_ch_vld,
    output logic [NCH-1:0][DATA_W-1:0]  rx_lane_data,
    output logic [NCH-1:0][SIDE_W-1:0]  rx_lane_side,
    output logic [NCH-1:0]              rx_lane_vld
);

    map_cfg_t cfg;

    laneswap_cfg i_cfg (
        .clk       (clk),
        .rst       (rst),
        .link_hold (link_hold),
        .cfg_load  (cfg_load),
        .flip_in   (flip_in),
        .width_in  (width_in),
        .cfg       (cfg)
    );

    laneswap_path #(
        .DATA_W    (DATA_W),
        .SIDE_W    (SIDE_W),
        .IS_TX     (1'b1),
        .IDLE_WORD (IDLE_WORD)
    ) i_tx (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .in_data  (tx_lane_data),
        .in_side  (tx_lane_side),
        .in_vld   (tx_lane_vld),
        .out_data (tx_ch_data),
        .out_side (tx_ch_side),
        .out_vld  (tx_ch_vld)
    );

    laneswap_path #(
        .DATA_W    (DATA_W),
        .SIDE_W    (SIDE_W),
        .IS_TX     (1'b0),
        .IDLE_WORD (IDLE_WORD)
    ) i_rx (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .in_data  (rx_ch_data),
        .in_side  (rx_ch_side),
        .in_vld   (rx_ch_vld),
        .out_data (rx_lane_data),
        .out_side (rx_lane_side),
        .out_vld  (rx_lane_vld)
    );

endmodule

// File: tb/test_lane_swap_xbar.sv
`timescale 1ns/1ps
module test_lane_swap_xbar;

    localparam int DW = 16;
    localparam int SW = 2;
    localparam logic [DW-1:0] IDLE = 16'hBC1C;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, link_hold, cfg_load, flip_in;
    logic [1:0] width_in;
    logic [3:0][DW-1:0] tx_lane_data, tx_ch_data, rx_ch_data, rx_lane_data;
    logic [3:0][SW-1:0] tx_lane_side, tx_ch_side, rx_ch_side, rx_lane_side;
    logic [3:0] tx_lane_vld, tx_ch_vld, rx_ch_vld, rx_lane_vld;

    lane_swap_xbar #(.DATA_W(DW), .SIDE_W(SW), .IDLE_WORD(IDLE)) i_lane_swap_xbar (
        .clk(clk), .rst(rst), .link_hold(link_hold), .cfg_load(cfg_load),
        .flip_in(flip_in), .width_in(width_in),
        .tx_lane_data(tx_lane_data), .tx_lane_side(tx_lane_side), .tx_lane_vld(tx_lane_vld),
        .tx_ch_data(tx_ch_data), .tx_ch_side(tx_ch_side), .tx_ch_vld(tx_ch_vld),
        .rx_ch_data(rx_ch_data), .rx_ch_side(rx_ch_side), .rx_ch_vld(rx_ch_vld),
        .rx_lane_data(rx_lane_data), .rx_lane_side(rx_lane_side), .rx_lane_vld(rx_lane_vld)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R1";

    // Reference model state
    bit m_flip = 1'b0;
    int m_lanes = 4;
    logic [DW+SW:0] exp_tx[4];
    logic [DW+SW:0] exp_rx[4];
    bit exp_ok = 1'b0;

    function automatic int lanes_of(logic [1:0] code);
        if (code == 2'd0) return 1;
        if (code == 2'd1) return 2;
        return 4;
    endfunction

    task automatic compare();
        for (int c = 0; c < 4; c++) begin
            logic [DW+SW:0] got_t, got_r;
            got_t = {tx_ch_vld[c], tx_ch_side[c], tx_ch_data[c]};
            got_r = {rx_lane_vld[c], rx_lane_side[c], rx_lane_data[c]};
            checks++;
            if (got_t !== exp_tx[c]) begin
                errors++;
                $display("FAIL %s tx channel %0d got %h expected %h", tag, c, got_t, exp_tx[c]);
            end
            checks++;
            if (got_r !== exp_rx[c]) begin
                errors++;
                $display("FAIL %s rx lane %0d got %h expected %h", tag, c, got_r, exp_rx[c]);
            end
        end
    endtask

    // Predict what the outputs hold after the coming edge, then advance the model.
    task automatic predict();
        int chan_lane[4];
        for (int c = 0; c < 4; c++) chan_lane[c] = m_flip ? 3 - c : c;
        for (int c = 0; c < 4; c++) begin
            if (rst || chan_lane[c] >= m_lanes)
                exp_tx[c] = {1'b0, {SW{1'b0}}, IDLE};
            else
                exp_tx[c] = {tx_lane_vld[chan_lane[c]], tx_lane_side[chan_lane[c]],
                             tx_lane_data[chan_lane[c]]};
        end
        for (int l = 0; l < 4; l++) begin
            int ch;
            ch = m_flip ? 3 - l : l;
            if (rst || l >= m_lanes)
                exp_rx[l] = '0;
            else
                exp_rx[l] = {rx_ch_vld[ch], rx_ch_side[ch], rx_ch_data[ch]};
        end
        if (rst) begin
            m_flip = 1'b0;
            m_lanes = 4;
        end else if (cfg_load && link_hold && width_in != 2'd3) begin
            m_flip = flip_in;
            m_lanes = lanes_of(width_in);
        end
        exp_ok = 1'b1;
    endtask

    task automatic rand_traffic();
        for (int i = 0; i < 4; i++) begin
            tx_lane_data[i] = DW'($urandom);
            tx_lane_side[i] = SW'($urandom);
            tx_lane_vld[i]  = 1'($urandom);
            rx_ch_data[i]   = DW'($urandom);
            rx_ch_side[i]   = SW'($urandom);
            rx_ch_vld[i]    = 1'($urandom);
        end
    endtask

    // One cycle: check the last edge, drive new inputs, predict the next edge.
    task automatic step(input bit r, input bit hold, input bit ld, input bit f, input logic [1:0] w);
        @(negedge clk);
        if (exp_ok) compare();
        rst = r; link_hold = hold; cfg_load = ld; flip_in = f; width_in = w;
        rand_traffic();
        predict();
    endtask

    task automatic traffic(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 1'($urandom), 2'($urandom));
    endtask

    task automatic load_cfg(input bit f, input logic [1:0] w);
        step(1'b0, 1'b1, 1'b0, f, w);
        step(1'b0, 1'b1, 1'b1, f, w);
        step(1'b0, 1'b1, 1'b0, f, w);
    endtask

    initial begin
        rst = 1'b1; link_hold = 1'b0; cfg_load = 1'b0; flip_in = 1'b0; width_in = 2'd2;
        rand_traffic();
        tag = "R1";
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b1, 1'b1, 2'd0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 2'd2);
        tag = "R2 R7 R8";
        traffic(20);
        tag = "R9";
        load_cfg(1'b1, 2'd2);
        tag = "R3";
        traffic(20);
        tag = "R9";
        step(1'b0, 1'b0, 1'b1, 1'b0, 2'd0);   // strobe without hold: ignored
        traffic(6);
        tag = "R4 R6";
        load_cfg(1'b1, 2'd1);
        traffic(20);
        tag = "R5";
        load_cfg(1'b1, 2'd0);
        traffic(15);
        load_cfg(1'b0, 2'd0);
        traffic(15);
        tag = "R2 R6";
        load_cfg(1'b0, 2'd1);
        traffic(15);
        tag = "R10";
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'd3);
        traffic(10);
        tag = "R7 R8 R9";
        for (int k = 0; k < 400; k++)
            step(1'b0, 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom), 2'($urandom));
        tag = "R1";
        step(1'b1, 1'b0, 1'b0, 1'b0, 2'd2);
        traffic(5);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule